// File: doc/BRIEF.md
# Multichannel PWM Generator with Register Decode

This block produces up to eight independent pulse-width-modulated outputs. Software programs it over a simple memory-mapped bus. The bus has a write strobe, a read strobe, a 12-bit byte address and 32-bit data.

A global enable register holds one bit per channel. Each channel has a window of registers at its own base address, holding:

- a control word with a mode bit and a power-of-two prescaler code,
- a 13-bit period count,
- a duty threshold.

Each running channel counts from 0 to period−1 and drives its output high while the count is below the threshold. A shared clock-select register decides how the counters advance. With the bus clock selected, they can advance on every cycle. With the fixed reference selected, they advance only on cycles where the reference tick input is high.

Period, threshold and prescaler changes are held back until the current period ends, so no partial pulses appear. Disabling a channel forces its output low and rewinds it. Enabling it again restarts a fresh period.

Top module: `pwm_bank`

## Requirements
- R1: The global enable register sits at address 0x000. Bit n runs channel n. It reads back the value last written.
- R2: Channel windows start at 0x010, 0x050, 0x090, 0x0D0, 0x110, 0x150, 0x190 and 0x220 for channels 0 to 7. Within a window, the offsets are:
  - control at +0x00, reading back as bit 15 (mode) and bits 2:0 (prescaler code), other bits 0;
  - period at +0x2C, bits 12:0;
  - threshold at +0x30, bits 12:0.
- R3: After a write to the enable register clears bit n, output n is low in the cycle right after the write edge. A later enable restarts channel n at count 0 with its prescaler cleared.
- R4: Let channel n be enabled at write edge E0, with mode set, period P, threshold T and prescaler divide d. In the cycle after edge E0+j, the output equals (floor(j/d) mod P) < T. For P of 0 or 1, the count stays at 0.
- R5: Prescaler code k (0..7) in control bits 2:0 gives d = 2^k. The count advances once every d ticks.
- R6: A channel whose control bit 15 (mode) is 0 keeps its output low, even when its enable bit is set.
- R7: Register 0x210 selects the tick source and reads back as 0 or 1.
  - Writing 0 selects the bus clock, where every cycle is a tick.
  - Writing any nonzero value selects the reference, where only cycles with ref_tick high are ticks.
  - With the reference selected and ref_tick low, outputs hold.
- R8: A threshold of 0 gives a constant low output. A threshold of at least the period gives a constant high output.
- R9: New period, threshold and prescaler values written while a channel runs take effect only when its count wraps to 0.
- R10: Any address other than those in R1, R2 and R7 reads as 0 and ignores writes. This covers the reserved window offsets +0x04, +0x08, +0x0C and +0x28, and misaligned addresses.
- R11: After reset, every register reads 0 and every output is low.
- R12: Read data appears in the cycle after the edge that samples rd_en. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| ref_tick | input | 1 | Tick strobe of the fixed reference clock |
| rdata | output | 32 | Registered read data |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
Every output is decoded from registered state without further registers.

- **Register writes:** the effect of a write appears in the cycle right after the edge that captured it. This is the edge index j = 0 of the waveform model.
- **Reads:** read data is due one cycle after the read strobe's edge.
- **Counting:** each count step lands exactly d ticks after the previous one.

The bench drives and samples only on falling clock edges. It therefore observes each result in the first cycle it is due. It compares each result against a bench function of j, P, T and d, or against the old and new threshold either side of the wrap edge.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    parameter int ADDR_W = 12;
    parameter int DATA_W = 32;
    parameter int PER_W  = 13;
    parameter int PSC_W  = 3;

    localparam int MODE_BIT = 15;

    localparam logic [ADDR_W-1:0] GEN_ADDR   = ADDR_W'('h000);
    localparam logic [ADDR_W-1:0] CKSEL_ADDR = ADDR_W'('h210);
    localparam logic [ADDR_W-1:0] OFF_CTRL   = ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] OFF_PER    = ADDR_W'('h2C);
    localparam logic [ADDR_W-1:0] OFF_THR    = ADDR_W'('h30);

    typedef struct packed {
        logic             mode;
        logic [PSC_W-1:0] psc;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] thr;
    } chan_cfg_t;

    // Window bases: even 0x40 stride from 0x010, except the last channel.
    function automatic logic [ADDR_W-1:0] win_base(input int ch);
        if (ch == 7) begin
            return ADDR_W'('h220);
        end
        return ADDR_W'('h010 + 'h040 * ch);
    endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs import pwm_pkg::*; #(
    parameter int NCH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    output logic [NCH-1:0]         en_o,
    output logic                   ref_sel_o,
    output chan_cfg_t [NCH-1:0]    cfg_o
);
    logic [NCH-1:0][DATA_W-1:0] ch_rd;
    logic [DATA_W-1:0]          rd_mux;
    logic                       unused_wdata;

    assign unused_wdata = ^wdata;

    // Global enable and clock select
    always_ff @(posedge clk) begin
        if (rst) begin
            en_o      <= '0;
            ref_sel_o <= 1'b0;
        end else if (wr_en) begin
            if (addr == GEN_ADDR)   en_o      <= wdata[NCH-1:0];
            if (addr == CKSEL_ADDR) ref_sel_o <= |wdata;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = win_base(c);
        logic              hit_ctrl, hit_per, hit_thr;
        chan_cfg_t         cfg_q;
        logic [DATA_W-1:0] rd_c;

        assign hit_ctrl = (addr == BASE + OFF_CTRL);
        assign hit_per  = (addr == BASE + OFF_PER);
        assign hit_thr  = (addr == BASE + OFF_THR);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q <= '0;
            end else if (wr_en) begin
                if (hit_ctrl) begin
                    cfg_q.mode <= wdata[MODE_BIT];
                    cfg_q.psc  <= wdata[PSC_W-1:0];
                end
                if (hit_per) cfg_q.per <= wdata[PER_W-1:0];
                if (hit_thr) cfg_q.thr <= wdata[PER_W-1:0];
            end
        end

        always_comb begin
            rd_c = '0;
            if (hit_ctrl) begin
                rd_c[MODE_BIT]    = cfg_q.mode;
                rd_c[PSC_W-1:0]   = cfg_q.psc;
            end
            if (hit_per) rd_c[PER_W-1:0] = cfg_q.per;
            if (hit_thr) rd_c[PER_W-1:0] = cfg_q.thr;
        end

        assign cfg_o[c] = cfg_q;
        assign ch_rd[c] = rd_c;
    end

    always_comb begin
        rd_mux = '0;
        if (addr == GEN_ADDR)   rd_mux[NCH-1:0] = en_o;
        if (addr == CKSEL_ADDR) rd_mux[0]       = ref_sel_o;
        for (int c = 0; c < NCH; c++) begin
            rd_mux = rd_mux | ch_rd[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan import pwm_pkg::*; (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      tick,
    input  chan_cfg_t cfg,
    output logic      pwm
);
    localparam int PRE_W = 2 ** PSC_W;

    chan_cfg_t        act_q;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_lim;
    logic [PER_W-1:0] cnt_q;
    logic [PER_W:0]   cnt_inc;
    logic             step, at_end;
    logic             unused_mode;

    assign unused_mode = act_q.mode;
    assign pre_lim     = PRE_W'((32'd1 << act_q.psc) - 32'd1);
    assign step        = tick && (pre_q == pre_lim);
    assign cnt_inc     = {1'b0, cnt_q} + (PER_W+1)'(1);
    assign at_end      = (cnt_inc >= {1'b0, act_q.per});

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            cnt_q <= '0;
            act_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
            cnt_q <= '0;
            act_q <= cfg;
        end else if (step) begin
            pre_q <= '0;
            if (at_end) begin
                cnt_q <= '0;
                act_q <= cfg;
            end else begin
                cnt_q <= cnt_inc[PER_W-1:0];
            end
        end else if (tick) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    assign pwm = run && (cnt_q < act_q.thr);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank import pwm_pkg::*; #(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ref_tick,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    pwm_out
);
    logic [NCH-1:0]      en_vec;
    logic                ref_sel;
    chan_cfg_t [NCH-1:0] cfg_vec;
    logic                tick;

    assign tick = ref_sel ? ref_tick : 1'b1;

    pwm_regs #(.NCH(NCH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .en_o      (en_vec),
        .ref_sel_o (ref_sel),
        .cfg_o     (cfg_vec)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm_chan u_chan (
            .clk  (clk),
            .rst  (rst),
            .run  (en_vec[c] & cfg_vec[c].mode),
            .tick (tick),
            .cfg  (cfg_vec[c]),
            .pwm  (pwm_out[c])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk import pwm_pkg::*; #(
    parameter int NCH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              ref_tick,
    input logic              ref_sel,
    input logic [DATA_W-1:0] rdata,
    input logic [NCH-1:0]    pwm_out
);
    p_reset_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!rst && $past(rst)) |-> (pwm_out == '0 && rdata == '0));

    p_disable_low_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == GEN_ADDR) |=> ((pwm_out & ~$past(wdata[NCH-1:0])) == '0));

    p_unaligned_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[1:0] != 2'b00) |=> (rdata == '0));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    p_ref_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (ref_sel && !ref_tick && !wr_en) |=> $stable(pwm_out));
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .ref_tick (ref_tick),
    .ref_sel  (ref_sel),
    .rdata    (rdata),
    .pwm_out  (pwm_out)
);

// File: tb/test_pwm_bank.sv
module test_pwm_bank;
    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic           ref_tick = 1'b0;
    logic [11:0]    addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic [NCH-1:0] pwm_out;
    int             errors = 0;
    int             checks = 0;

    always #4 clk = ~clk;

    pwm_bank #(.NCH(NCH)) i_pwm_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .ref_tick(ref_tick), .rdata(rdata), .pwm_out(pwm_out)
    );

    function automatic logic [11:0] base(int ch);
        return (ch == 7) ? 12'h220 : 12'(12'h010 + 64 * ch);
    endfunction

    function automatic logic model(int j, int per, int thr, int d);
        int cnt;
        cnt = (per <= 1) ? 0 : ((j / d) % per);
        return cnt < thr;
    endfunction

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        check(v == exp, tag, v, exp);
    endtask

    task automatic cfg(input int ch, input int psc, input int per, input int thr, input bit mode);
        wr(base(ch) + 12'h000, (32'(mode) << 15) | 32'(psc));
        wr(base(ch) + 12'h02C, 32'(per));
        wr(base(ch) + 12'h030, 32'(thr));
    endtask

    task automatic run_check(input int ch, input int per, input int thr, input int d,
                             input int n, input string tag);
        for (int j = 0; j < n; j++) begin
            logic e;
            e = model(j, per, thr, d);
            check(pwm_out[ch] == e && (pwm_out & ~(NCH'(1) << ch)) == '0, tag,
                  pwm_out, NCH'(e) << ch);
            @(negedge clk);
        end
    endtask

    task automatic hold_check(input int ch, input logic lvl, input int n, input string tag);
        for (int j = 0; j < n; j++) begin
            check(pwm_out[ch] == lvl, tag, pwm_out[ch], lvl);
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        check(pwm_out == '0, "R11 outputs after reset", pwm_out, 0);
        rd_check(12'h000, 0, "R11 enable reg");
        rd_check(12'h210, 0, "R11 clock select");
        rd_check(base(0), 0, "R11 ch0 control");
        rd_check(base(7) + 12'h02C, 0, "R11 ch7 period");
        rd_check(base(3) + 12'h030, 0, "R11 ch3 threshold");

        // R2: window table and field widths
        for (int c = 0; c < NCH; c++) wr(base(c) + 12'h02C, 32'(100 + c));
        for (int c = 0; c < NCH; c++) rd_check(base(c) + 12'h02C, 32'(100 + c), "R2 window period");
        wr(base(2), 32'hFFFF_FFFF);
        rd_check(base(2), 32'h0000_8007, "R2 control fields");
        wr(base(2) + 12'h02C, 32'h0000_FFFF);
        rd_check(base(2) + 12'h02C, 32'h0000_1FFF, "R2 period 13 bits");
        wr(base(2) + 12'h030, 32'h0001_2345);
        rd_check(base(2) + 12'h030, 32'h0000_0345, "R2 threshold 13 bits");

        // R1: global enable readback
        wr(12'h000, 32'h0000_00A5);
        rd_check(12'h000, 32'h0000_00A5, "R1 enable readback");
        wr(12'h000, 0);

        // R4 and R5: directed waveforms
        cfg(2, 0, 5, 2, 1'b1);
        wr(12'h000, 32'h04);
        run_check(2, 5, 2, 1, 15, "R4 ch2 P5 T2 d1");
        wr(12'h000, 0);
        cfg(3, 2, 3, 1, 1'b1);
        wr(12'h000, 32'h08);
        run_check(3, 3, 1, 4, 30, "R5 ch3 P3 T1 d4");
        wr(12'h000, 0);

        // R8: threshold extremes
        cfg(1, 0, 4, 0, 1'b1);
        wr(12'h000, 32'h02);
        hold_check(1, 1'b0, 20, "R8 threshold zero");
        wr(12'h000, 0);
        cfg(1, 1, 4, 7, 1'b1);
        wr(12'h000, 32'h02);
        hold_check(1, 1'b1, 20, "R8 threshold above period");
        wr(12'h000, 0);

        // R6: mode bit clear
        cfg(4, 0, 4, 2, 1'b0);
        wr(12'h000, 32'h10);
        hold_check(4, 1'b0, 20, "R6 mode clear keeps low");
        wr(12'h000, 0);

        // R3: disable and restart
        cfg(5, 1, 6, 3, 1'b1);
        wr(12'h000, 32'h20);
        run_check(5, 6, 3, 2, 7, "R3 before disable");
        wr(12'h000, 0);
        hold_check(5, 1'b0, 5, "R3 low after disable");
        wr(12'h000, 32'h20);
        run_check(5, 6, 3, 2, 24, "R3 restart from zero");
        wr(12'h000, 0);

        // R9: shadowed threshold
        cfg(0, 0, 4, 1, 1'b1);
        wr(12'h000, 32'h01);
        check(pwm_out[0] == 1'b1, "R9 first cycle old threshold", pwm_out[0], 1);
        wr(base(0) + 12'h030, 32'd3);
        for (int j = 1; j < 12; j++) begin
            logic e;
            e = model(j, 4, (j < 4) ? 1 : 3, 1);
            check(pwm_out[0] == e, "R9 threshold applied at wrap", pwm_out[0], e);
            @(negedge clk);
        end
        wr(12'h000, 0);

        // R7: reference tick source
        wr(12'h210, 32'd5);
        rd_check(12'h210, 32'd1, "R7 select readback");
        cfg(6, 0, 4, 1, 1'b1);
        wr(12'h000, 32'h40);
        hold_check(6, 1'b1, 20, "R7 frozen without ref tick");
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
        check(pwm_out[6] == 1'b0, "R7 one ref tick advances", pwm_out[6], 0);
        hold_check(6, 1'b0, 6, "R7 frozen after tick");
        wr(12'h000, 0);
        wr(12'h210, 0);
        rd_check(12'h210, 0, "R7 select back to bus clock");

        // R10: unmapped and reserved
        wr(base(0) + 12'h004, 32'hFFFF);
        rd_check(base(0) + 12'h004, 0, "R10 reserved offset");
        wr(12'h004, 32'hFF);
        rd_check(12'h000, 0, "R10 enable untouched");
        check(pwm_out == '0, "R10 outputs untouched", pwm_out, 0);
        rd_check(base(0) + 12'h030, 32'd3, "R10 neighbour intact");
        rd_check(12'h3FC, 0, "R10 unmapped address");
        rd_check(12'h011, 0, "R10 misaligned address");

        // R12: read data hold
        wr(base(1) + 12'h02C, 32'd77);
        rd(base(1) + 12'h02C, v);
        wr(base(1) + 12'h02C, 32'd55);
        repeat (3) @(negedge clk);
        check(rdata == 32'd77, "R12 rdata holds", rdata, 77);
        rd_check(base(1) + 12'h02C, 32'd55, "R12 next read");

        // R4 random configurations
        for (int it = 0; it < 10; it++) begin
            int ch, psc, per, thr, d;
            ch  = $urandom_range(0, NCH - 1);
            psc = $urandom_range(0, 2);
            per = $urandom_range(1, 10);
            thr = $urandom_range(0, per + 1);
            d   = 1 << psc;
            cfg(ch, psc, per, thr, 1'b1);
            wr(12'h000, 32'(1) << ch);
            run_check(ch, per, thr, d, 2 * per * d + 3, "R4 random config");
            wr(12'h000, 0);
        end

        finish_run();
    end
endmodule